// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general-purpose registers and lets a datapath reach each one at full width or through a narrower window onto its low half. A two-bit view selector chooses the window: the whole word, bits 15:0, bits 7:0, or bits 15:8. Two combinational read ports and one write port, which updates on the clock edge, share the same view encoding. A narrow read returns its field zero-extended into a 32-bit result. A narrow write merges its field into the stored word, so every other bit of the register is kept.

Only the first four registers can be reached through the two byte windows. A byte-window access to any of the upper four registers is illegal. Such a write is dropped and such a read returns zero. Either case raises an error flag for one cycle. The last register is the stack pointer, and its contents are always visible on a dedicated output.

Top module: `gpr_view_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero and clears `view_err`.
- R2: A write with view 2'b00 stores all 32 bits of `wr_data`, and a read with view 2'b00 returns the full stored word.
- R3: A read with view 2'b01 returns bits 15:0 of the register in result bits 15:0, and result bits 31:16 are zero.
- R4: A read with view 2'b10 on registers 0 to 3 returns bits 7:0 of the register in result bits 7:0, and result bits 31:8 are zero.
- R5: A read with view 2'b11 on registers 0 to 3 returns bits 15:8 of the register in result bits 7:0, and result bits 31:8 are zero.
- R6: A write with view 2'b01 replaces register bits 15:0 with `wr_data[15:0]` and leaves bits 31:16 unchanged.
- R7: A write with view 2'b10 or 2'b11 on registers 0 to 3 places `wr_data[7:0]` into bits 7:0 or bits 15:8 respectively and leaves all other bits unchanged.
- R8: A byte-view access (view 2'b10 or 2'b11) to registers 4 to 7 is illegal. An illegal write changes no register, and an illegal read returns zero. `view_err` is high in the cycle after any illegal access (an enabled write or either read port) and low in the cycle after a cycle with none.
- R9: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle.
- R10: `sp_out` always shows the full contents of register 7 (the stack pointer) and changes only after a write to register 7 or a reset.
- R11: The two read ports select register and view independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register index to write |
| wr_view | input | 2 | View for the write |
| wr_data | input | 32 | Write data; narrow views take its low bits |
| ra_idx | input | 3 | Read port A register index |
| ra_view | input | 2 | Read port A view |
| ra_data | output | 32 | Read port A result, zero-extended |
| rb_idx | input | 3 | Read port B register index |
| rb_view | input | 2 | Read port B view |
| rb_data | output | 32 | Read port B result, zero-extended |
| sp_out | output | 32 | Contents of register 7 |
| view_err | output | 1 | One-cycle flag after an illegal byte-view access |

## Verification
The bench runs a chain of narrow writes on one register and confirms after each one that only the selected field moved. A design that overwrites the whole word, or fills the unselected bits with zeros, shows up at once on the full-width readback. It reads the high byte to catch a window that is off by eight bits, and it looks at the upper result bits of narrow reads to catch missing zero-extension. It drives byte-view writes to the upper four registers and reads those registers back, so a design that lets the write through or returns live data on an illegal read is exposed. The error pulse is checked for its exact cycle and for dropping again afterwards. A read in the same cycle as a write to the same register must return the old value, which catches a design that forwards the write data early.

// File: rtl/gpr_view_pkg.sv
package gpr_view_pkg;

  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    VW_WORD = 2'b00,
    VW_HALF = 2'b01,
    VW_LOB  = 2'b10,
    VW_HIB  = 2'b11
  } view_e;

  // Byte windows exist only below byte_regs.
  function automatic logic view_ok(input int unsigned idx, input int unsigned byte_regs,
                                   input view_e v);
    logic is_byte;
    is_byte = (v == VW_LOB) || (v == VW_HIB);
    return !is_byte || (idx < byte_regs);
  endfunction

  // Pull a field out of a word and zero-extend it.
  function automatic word_t view_extract(input word_t w, input view_e v);
    word_t r;
    case (v)
      VW_WORD: r = w;
      VW_HALF: r = {{(WORD_W-16){1'b0}}, w[15:0]};
      VW_LOB:  r = {{(WORD_W-8){1'b0}}, w[7:0]};
      default: r = {{(WORD_W-8){1'b0}}, w[15:8]};
    endcase
    return r;
  endfunction

  // Fold the low bits of nw into the chosen field of old.
  function automatic word_t view_merge(input word_t old, input word_t nw, input view_e v);
    word_t r;
    case (v)
      VW_WORD: r = nw;
      VW_HALF: r = {old[WORD_W-1:16], nw[15:0]};
      VW_LOB:  r = {old[WORD_W-1:8], nw[7:0]};
      default: r = {old[WORD_W-1:16], nw[7:0], old[7:0]};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpr_cell.sv
module gpr_cell
  import gpr_view_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t d,
  output word_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_view_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  word_t            regs_q [NUM_REGS],
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_view,
  output word_t            rd_data,
  output logic             rd_illegal
);
  word_t selected;
  logic  legal;

  always_comb begin
    selected   = regs_q[rd_idx];
    legal      = view_ok({{(32-IDX_W){1'b0}}, rd_idx}, BYTE_REGS, view_e'(rd_view));
    rd_data    = legal ? view_extract(selected, view_e'(rd_view)) : '0;
    rd_illegal = !legal;
  end
endmodule

// File: rtl/gpr_write_unit.sv
module gpr_write_unit
  import gpr_view_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  word_t            regs_q [NUM_REGS],
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_view,
  input  word_t            wr_data,
  output logic             cell_we [NUM_REGS],
  output word_t            cell_d,
  output logic             wr_blocked
);
  logic legal;

  always_comb begin
    legal      = view_ok({{(32-IDX_W){1'b0}}, wr_idx}, BYTE_REGS, view_e'(wr_view));
    wr_blocked = wr_en && !legal;
    cell_d     = view_merge(regs_q[wr_idx], wr_data, view_e'(wr_view));
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_we
    assign cell_we[gi] = wr_en && legal && (wr_idx == IDX_W'(gi));
  end
endmodule

// File: rtl/gpr_view_file.sv
module gpr_view_file
  import gpr_view_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned SP_IDX   = NUM_REGS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_view,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_view,
  output logic [31:0]      ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_view,
  output logic [31:0]      rb_data,
  output logic [31:0]      sp_out,
  output logic             view_err
);
  word_t regs_q [NUM_REGS];
  logic  cell_we [NUM_REGS];
  word_t cell_d;

  // Named events, visible to the bound checker.
  logic wr_blocked;
  logic rd_a_illegal;
  logic rd_b_illegal;

  gpr_write_unit #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS), .IDX_W(IDX_W)) i_wr (
    .regs_q(regs_q), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
    .wr_data(wr_data), .cell_we(cell_we), .cell_d(cell_d), .wr_blocked(wr_blocked)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
    gpr_cell i_cell (
      .clk(clk), .rst(rst), .we(cell_we[gi]), .d(cell_d), .q(regs_q[gi])
    );
  end

  gpr_read_port #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS), .IDX_W(IDX_W)) i_rd_a (
    .regs_q(regs_q), .rd_idx(ra_idx), .rd_view(ra_view),
    .rd_data(ra_data), .rd_illegal(rd_a_illegal)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS), .IDX_W(IDX_W)) i_rd_b (
    .regs_q(regs_q), .rd_idx(rb_idx), .rd_view(rb_view),
    .rd_data(rb_data), .rd_illegal(rd_b_illegal)
  );

  assign sp_out = regs_q[SP_IDX];

  always_ff @(posedge clk) begin
    if (rst) view_err <= 1'b0;
    else     view_err <= wr_blocked || rd_a_illegal || rd_b_illegal;
  end
endmodule

// File: rtl/gpr_view_file_chk.sv
module gpr_view_file_chk #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned SP_IDX = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_view,
  input logic [31:0]      wr_data,
  input logic [1:0]       ra_view,
  input logic [31:0]      ra_data,
  input logic [31:0]      sp_out,
  input logic             view_err,
  input logic             wr_blocked,
  input logic             rd_a_illegal,
  input logic             rd_b_illegal
);
  logic sp_hit;
  assign sp_hit = wr_en && (wr_idx == IDX_W'(SP_IDX));

  assert_half_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (ra_view == 2'b01) |-> (ra_data[31:16] == 16'h0));

  assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
    ra_view[1] |-> (ra_data[31:8] == 24'h0));

  assert_half_keeps_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (sp_hit && wr_view == 2'b01) |=> (sp_out[31:16] == $past(sp_out[31:16])));

  assert_illegal_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rd_a_illegal |-> (ra_data == 32'h0));

  assert_err_after_block_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_blocked || rd_a_illegal || rd_b_illegal) |=> view_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_blocked || rd_a_illegal || rd_b_illegal) |=> !view_err);

  assert_blocked_keeps_sp_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_blocked && wr_idx == IDX_W'(SP_IDX)) |=> $stable(sp_out));

  assert_sp_full_write_R10: assert property (@(posedge clk) disable iff (rst)
    (sp_hit && wr_view == 2'b00) |=> (sp_out == $past(wr_data)));

  assert_sp_untouched_R10: assert property (@(posedge clk) disable iff (rst)
    !sp_hit |=> $stable(sp_out));
endmodule

bind gpr_view_file gpr_view_file_chk #(.IDX_W(IDX_W), .SP_IDX(SP_IDX)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
  .wr_data(wr_data), .ra_view(ra_view), .ra_data(ra_data), .sp_out(sp_out),
  .view_err(view_err), .wr_blocked(wr_blocked), .rd_a_illegal(rd_a_illegal),
  .rd_b_illegal(rd_b_illegal)
);

// File: tb/test_gpr_view_file.sv
module test_gpr_view_file;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic [2:0]  ra_idx;
  logic [1:0]  ra_view;
  logic [31:0] ra_data;
  logic [2:0]  rb_idx;
  logic [1:0]  rb_view;
  logic [31:0] rb_data;
  logic [31:0] sp_out;
  logic        view_err;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  gpr_view_file i_gpr_view_file (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
    .wr_data(wr_data), .ra_idx(ra_idx), .ra_view(ra_view), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_view(rb_view), .rb_data(rb_data), .sp_out(sp_out),
    .view_err(view_err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [2:0]  wi;
    logic [1:0]  wv;
    logic [31:0] wd;
    logic [2:0]  ri;
    logic [1:0]  rv;
    logic [31:0] ex;
  } vec_t;

  // Views: 00 word, 01 low half, 10 low byte, 11 high byte.
  localparam vec_t VEC [14] = '{
    '{4'd2,  1'b1, 3'd0, 2'b00, 32'h11223344, 3'd0, 2'b00, 32'h11223344}, // R2
    '{4'd6,  1'b1, 3'd0, 2'b01, 32'hAAAA5566, 3'd0, 2'b00, 32'h11225566}, // R6
    '{4'd7,  1'b1, 3'd0, 2'b10, 32'h000000F0, 3'd0, 2'b00, 32'h112255F0}, // R7
    '{4'd7,  1'b1, 3'd0, 2'b11, 32'h0000009C, 3'd0, 2'b00, 32'h11229CF0}, // R7
    '{4'd3,  1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b01, 32'h00009CF0}, // R3
    '{4'd4,  1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b10, 32'h000000F0}, // R4
    '{4'd5,  1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b11, 32'h0000009C}, // R5
    '{4'd5,  1'b1, 3'd3, 2'b00, 32'hDEADBEEF, 3'd3, 2'b11, 32'h000000BE}, // R5
    '{4'd3,  1'b1, 3'd5, 2'b00, 32'hCAFEF00D, 3'd5, 2'b01, 32'h0000F00D}, // R3
    '{4'd8,  1'b1, 3'd5, 2'b10, 32'h00000012, 3'd5, 2'b00, 32'hCAFEF00D}, // R8
    '{4'd2,  1'b1, 3'd7, 2'b00, 32'h0000FFF0, 3'd7, 2'b00, 32'h0000FFF0}, // R2
    '{4'd6,  1'b1, 3'd7, 2'b01, 32'h12345678, 3'd7, 2'b00, 32'h00005678}, // R6
    '{4'd8,  1'b1, 3'd6, 2'b00, 32'h87654321, 3'd6, 2'b11, 32'h00000000}, // R8
    '{4'd7,  1'b1, 3'd1, 2'b11, 32'h000000AB, 3'd1, 2'b00, 32'h0000AB00}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
    ra_idx = '0; ra_view = '0; rb_idx = '0; rb_view = '0;
  endtask

  task automatic check_all_zero(input string req);
    for (int i = 0; i < 8; i++) begin
      ra_idx = 3'(i); rb_idx = 3'(7 - i); ra_view = 2'b00; rb_view = 2'b00;
      #1;
      chk(req, ra_data, 32'h0);
      chk(req, rb_data, 32'h0);
    end
    chk(req, sp_out, 32'h0);
    chk(req, {31'h0, view_err}, 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    check_all_zero("R1 reset");

    // Table walk: write in one cycle, read back in the next.
    foreach (VEC[k]) begin
      @(negedge clk);
      ra_idx = '0; ra_view = 2'b00;
      wr_en = VEC[k].we; wr_idx = VEC[k].wi; wr_view = VEC[k].wv; wr_data = VEC[k].wd;
      @(negedge clk);
      wr_en = 1'b0;
      ra_idx = VEC[k].ri; ra_view = VEC[k].rv;
      #1;
      chk($sformatf("R%0d vector %0d", VEC[k].req, k), ra_data, VEC[k].ex);
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);

    // R10: stack pointer output after the table (reg 7 = 0x00005678)
    chk("R10 sp after table", sp_out, 32'h00005678);

    // R9: same-cycle read returns old value
    ra_idx = 3'd2; ra_view = 2'b00;
    wr_en = 1'b1; wr_idx = 3'd2; wr_view = 2'b00; wr_data = 32'h0BADF00D;
    #1;
    chk("R9 old value same cycle", ra_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R9 new value next cycle", ra_data, 32'h0BADF00D);

    // R11: two ports, different registers and views together
    ra_idx = 3'd3; ra_view = 2'b10;
    rb_idx = 3'd7; rb_view = 2'b01;
    #1;
    chk("R11 port A", ra_data, 32'h000000EF);
    chk("R11 port B", rb_data, 32'h00005678);
    ra_idx = '0; ra_view = '0; rb_idx = '0; rb_view = '0;

    // R8: illegal write to reg 4 raises error for one cycle, no change
    @(negedge clk);
    chk("R8 err low before", {31'h0, view_err}, 32'h0);
    wr_en = 1'b1; wr_idx = 3'd4; wr_view = 2'b11; wr_data = 32'h000000FF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 err after illegal write", {31'h0, view_err}, 32'h1);
    ra_idx = 3'd4; ra_view = 2'b00;
    #1;
    chk("R8 reg 4 untouched", ra_data, 32'h0);
    ra_idx = '0;
    @(negedge clk);
    chk("R8 err one cycle only", {31'h0, view_err}, 32'h0);

    // R8: illegal write to reg 7 leaves sp_out alone
    wr_en = 1'b1; wr_idx = 3'd7; wr_view = 2'b10; wr_data = 32'h00000011;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 sp kept on blocked write", sp_out, 32'h00005678);
    chk("R8 err after blocked sp write", {31'h0, view_err}, 32'h1);

    // R8: illegal read on port B returns zero and flags error
    rb_idx = 3'd6; rb_view = 2'b11;
    #1;
    chk("R8 illegal read zero", rb_data, 32'h0);
    @(negedge clk);
    rb_idx = '0; rb_view = '0;
    chk("R8 err after illegal read", {31'h0, view_err}, 32'h1);
    @(negedge clk);
    chk("R8 err clears", {31'h0, view_err}, 32'h0);

    // R10: full write to reg 7 shows on sp_out next cycle
    wr_en = 1'b1; wr_idx = 3'd7; wr_view = 2'b00; wr_data = 32'hFEEDC0DE;
    #1;
    chk("R10 sp before edge", sp_out, 32'h00005678);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 sp after write", sp_out, 32'hFEEDC0DE);

    // R1: reset in mid run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all_zero("R1 reset mid run");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule